// File: doc/BRIEF.md
# Operand Effective Address Unit

This unit turns an instruction's operand specifier into a usable operand. A caller presents a 4-bit addressing-mode code, an 8-bit address field, a register select and the program counter value that already points past the current instruction, then pulses `start`. The unit computes the effective address and performs the one or two memory reads that the mode needs. When the operand is ready, it pulses `done` for one cycle, with the effective address and the operand held on its outputs.

Register operands come from an external register file through a combinational select/data pair, which is sampled in the cycle of `start`. An internal index register serves the indexed modes. It can be loaded from outside and, in the auto-increment mode, steps by one after each use. Memory is reached through a single read port. The request is held until the memory returns ready, so any number of wait cycles is tolerated. Mode codes with no meaning are rejected with an error strobe.

Top module: `ea_resolve_unit`

## Requirements
- R1: Mode code 0 (immediate) returns the address field sign-extended to 16 bits as the operand, with field bit 7 as the sign. It reports an effective address of 0, makes no memory read, and raises `done` in the cycle after `start`.
- R2: Mode code 1 (direct) uses the zero-extended address field as the effective address and reads the operand from it in exactly one memory read.
- R3: Mode code 2 (indirect) reads a pointer at the zero-extended address field, uses that pointer as the effective address, and reads the operand there: two memory reads in that order.
- R4: Mode code 3 (register) returns the selected register as the operand, with effective address 0 and no memory read. Mode code 4 (register indirect) uses the selected register as the effective address, with one memory read.
- R5: Mode code 5 (relative) uses pc plus the zero-extended field, modulo 2^16, as the effective address. Mode code 6 (base displacement) uses the zero-extended field plus the selected register. Each makes one read.
- R6: Mode code 7 (indexed) uses the zero-extended field plus the index register, with one read. Mode code 8 does the same and then increments the index register by one. `idx_ld` loads the index register and takes priority over an increment in the same cycle.
- R7: Mode code 9 (pre-indexed) reads a pointer at field plus register and uses that pointer as the effective address before reading the operand, for two reads.
- R8: Mode code 10 (post-indexed) reads a pointer at the zero-extended field and uses pointer plus the selected register as the effective address before reading the operand, for two reads.
- R9: While `mem_req` is high and `mem_rdy` is low, `mem_req` stays high and `mem_addr` stays unchanged. Read data is taken in the cycle where both are high.
- R10: `done` is a one-cycle pulse in the cycle after the final read completes. A `start` that arrives while `busy` is high is ignored and produces no extra result.
- R11: Mode codes 11 to 15 raise `err` together with `done` in the cycle after `start`, with effective address and operand 0 and no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin resolving an operand (ignored while busy) |
| mode | input | 4 | Addressing-mode code |
| afield | input | 8 | Instruction address field |
| rsel | input | 3 | Register select |
| pc | input | 16 | Program counter after fetch |
| rf_sel | output | 3 | Register file read select |
| rf_data | input | 16 | Register file read data |
| idx_ld | input | 1 | Load the index register |
| idx_val | input | 16 | Value loaded into the index register |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdy | input | 1 | Memory read data valid |
| mem_rdata | input | 16 | Memory read data |
| busy | output | 1 | A resolution is in progress |
| done | output | 1 | Result valid pulse |
| err | output | 1 | Illegal mode pulse (with done) |
| ea | output | 16 | Effective address |
| operand | output | 16 | Operand value |

## Verification
The assertions assume that the register file returns data for `rf_sel` combinationally in the cycle of `start`. They also assume that the memory answers every request eventually and never raises `mem_rdy` without a request. The bench memory model follows this. It raises ready only while a request is pending, after a programmable number of wait cycles, and it returns a value computed from the address. The bench drives `start` only from a quiet state, except for one deliberate intrusion used to exercise the busy rule.

// File: rtl/ea_pkg.sv
package ea_pkg;

   typedef enum logic [3:0] {
      AM_IMM   = 4'd0,
      AM_DIR   = 4'd1,
      AM_IND   = 4'd2,
      AM_REG   = 4'd3,
      AM_RIND  = 4'd4,
      AM_REL   = 4'd5,
      AM_BASE  = 4'd6,
      AM_IDX   = 4'd7,
      AM_IDXAI = 4'd8,
      AM_PRE   = 4'd9,
      AM_POST  = 4'd10
   } amode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PTR  = 2'd1,
      ST_OPND = 2'd2
   } seq_e;

endpackage

// File: rtl/ea_index_reg.sv
module ea_index_reg #(
   parameter int AW         = 16,
   parameter bit AUTOINC_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [AW-1:0] ld_val,
   input  logic          inc,
   output logic [AW-1:0] x
);

   generate
      if (AUTOINC_EN) begin : g_step
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   x <= '0;
            else if (ld)  x <= ld_val;
            else if (inc) x <= x + 1'b1;
         end

         // R6
         autoinc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (inc && !ld) |=> (x == AW'($past(x) + 1'b1)));

         // R6
         load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ld |=> (x == $past(ld_val)));
      end else begin : g_fixed
         logic unused_inc;
         assign unused_inc = inc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  x <= '0;
            else if (ld) x <= ld_val;
         end
      end
   endgenerate

endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen #(
   parameter int AW         = 16,
   parameter int DW         = 16,
   parameter int FW         = 8,
   parameter int MW         = 4,
   parameter bit AUTOINC_EN = 1'b1
) (
   input  logic [MW-1:0] mode_i,
   input  logic [FW-1:0] afield,
   input  logic [DW-1:0] rval,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] xval,
   output logic [AW-1:0] first_addr,
   output logic          ptr_step,
   output logic          mem_step,
   output logic          post_add,
   output logic [DW-1:0] direct_data,
   output logic          bad_mode,
   output logic          inc_req
);
   import ea_pkg::*;

   localparam int AEXT = AW - FW;
   localparam int DEXT = DW - FW;

   logic [AW-1:0] a_z;
   logic [DW-1:0] a_s;
   logic [AW-1:0] r_a;

   assign a_z = {{AEXT{1'b0}}, afield};
   assign a_s = {{DEXT{afield[FW-1]}}, afield};
   assign r_a = rval[AW-1:0];

   always_comb begin
      first_addr  = '0;
      ptr_step    = 1'b0;
      mem_step    = 1'b1;
      post_add    = 1'b0;
      direct_data = '0;
      bad_mode    = 1'b0;
      inc_req     = 1'b0;
      case (amode_e'(mode_i))
         AM_IMM: begin
            mem_step    = 1'b0;
            direct_data = a_s;
         end
         AM_REG: begin
            mem_step    = 1'b0;
            direct_data = rval;
         end
         AM_DIR:  first_addr = a_z;
         AM_IND: begin
            first_addr = a_z;
            ptr_step   = 1'b1;
         end
         AM_RIND: first_addr = r_a;
         AM_REL:  first_addr = pc + a_z;
         AM_BASE: first_addr = a_z + r_a;
         AM_IDX:  first_addr = a_z + xval;
         AM_IDXAI: begin
            if (AUTOINC_EN) begin
               first_addr = a_z + xval;
               inc_req    = 1'b1;
            end else begin
               mem_step = 1'b0;
               bad_mode = 1'b1;
            end
         end
         AM_PRE: begin
            first_addr = a_z + r_a;
            ptr_step   = 1'b1;
         end
         AM_POST: begin
            first_addr = a_z;
            ptr_step   = 1'b1;
            post_add   = 1'b1;
         end
         default: begin
            mem_step = 1'b0;
            bad_mode = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/ea_seq.sv
module ea_seq #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] first_addr,
   input  logic          ptr_step,
   input  logic          mem_step,
   input  logic          post_add,
   input  logic [DW-1:0] direct_data,
   input  logic          bad_mode,
   input  logic [DW-1:0] rval,
   input  logic          mem_rdy,
   input  logic [DW-1:0] mem_rdata,
   output logic          accept,
   output logic          busy,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   output logic [AW-1:0] ea,
   output logic [DW-1:0] operand,
   output logic          done,
   output logic          err
);
   import ea_pkg::*;

   seq_e          st_q;
   logic [AW-1:0] addr_q;
   logic [AW-1:0] ea_q;
   logic [DW-1:0] opnd_q;
   logic [AW-1:0] radd_q;
   logic          post_q;
   logic          done_q;
   logic          err_q;
   logic [AW-1:0] ptr_next;

   assign accept   = start && (st_q == ST_IDLE);
   assign busy     = (st_q != ST_IDLE);
   assign mem_req  = busy;
   assign mem_addr = addr_q;
   assign ea       = ea_q;
   assign operand  = opnd_q;
   assign done     = done_q;
   assign err      = err_q;
   assign ptr_next = post_q ? (mem_rdata[AW-1:0] + radd_q) : mem_rdata[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         addr_q <= '0;
         ea_q   <= '0;
         opnd_q <= '0;
         radd_q <= '0;
         post_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  if (bad_mode) begin
                     ea_q   <= '0;
                     opnd_q <= '0;
                     err_q  <= 1'b1;
                     done_q <= 1'b1;
                  end else if (!mem_step) begin
                     ea_q   <= '0;
                     opnd_q <= direct_data;
                     done_q <= 1'b1;
                  end else if (ptr_step) begin
                     addr_q <= first_addr;
                     post_q <= post_add;
                     radd_q <= rval[AW-1:0];
                     st_q   <= ST_PTR;
                  end else begin
                     addr_q <= first_addr;
                     ea_q   <= first_addr;
                     st_q   <= ST_OPND;
                  end
               end
            end
            ST_PTR: begin
               if (mem_rdy) begin
                  addr_q <= ptr_next;
                  ea_q   <= ptr_next;
                  st_q   <= ST_OPND;
               end
            end
            ST_OPND: begin
               if (mem_rdy) begin
                  opnd_q <= mem_rdata;
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr)));

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10
   done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R11
   err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (done && (ea == '0) && (operand == '0)));

endmodule

// File: rtl/ea_resolve_unit.sv
module ea_resolve_unit #(
   parameter int AW         = 16,
   parameter int DW         = 16,
   parameter int FW         = 8,
   parameter int MW         = 4,
   parameter int RSW        = 3,
   parameter bit AUTOINC_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [MW-1:0]  mode,
   input  logic [FW-1:0]  afield,
   input  logic [RSW-1:0] rsel,
   input  logic [AW-1:0]  pc,
   output logic [RSW-1:0] rf_sel,
   input  logic [DW-1:0]  rf_data,
   input  logic           idx_ld,
   input  logic [AW-1:0]  idx_val,
   output logic           mem_req,
   output logic [AW-1:0]  mem_addr,
   input  logic           mem_rdy,
   input  logic [DW-1:0]  mem_rdata,
   output logic           busy,
   output logic           done,
   output logic           err,
   output logic [AW-1:0]  ea,
   output logic [DW-1:0]  operand
);
   import ea_pkg::*;

   generate
      if (MW != 4) begin : g_bad_mw
         $error("mode field must be 4 bits wide");
      end
      if (FW > AW) begin : g_bad_fw
         $error("address field wider than address");
      end
      if (AW > DW) begin : g_bad_aw
         $error("pointer data narrower than address");
      end
   endgenerate

   logic [AW-1:0] xval;
   logic [AW-1:0] first_addr;
   logic          ptr_step;
   logic          mem_step;
   logic          post_add;
   logic [DW-1:0] direct_data;
   logic          bad_mode;
   logic          inc_req;
   logic          accept;

   assign rf_sel = rsel;

   ea_addr_gen #(
      .AW(AW), .DW(DW), .FW(FW), .MW(MW), .AUTOINC_EN(AUTOINC_EN)
   ) u_gen (
      .mode_i     (mode),
      .afield     (afield),
      .rval       (rf_data),
      .pc         (pc),
      .xval       (xval),
      .first_addr (first_addr),
      .ptr_step   (ptr_step),
      .mem_step   (mem_step),
      .post_add   (post_add),
      .direct_data(direct_data),
      .bad_mode   (bad_mode),
      .inc_req    (inc_req)
   );

   ea_index_reg #(
      .AW(AW), .AUTOINC_EN(AUTOINC_EN)
   ) u_idx (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (idx_ld),
      .ld_val(idx_val),
      .inc   (accept && inc_req),
      .x     (xval)
   );

   ea_seq #(
      .AW(AW), .DW(DW)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .first_addr (first_addr),
      .ptr_step   (ptr_step),
      .mem_step   (mem_step),
      .post_add   (post_add),
      .direct_data(direct_data),
      .bad_mode   (bad_mode),
      .rval       (rf_data),
      .mem_rdy    (mem_rdy),
      .mem_rdata  (mem_rdata),
      .accept     (accept),
      .busy       (busy),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .ea         (ea),
      .operand    (operand),
      .done       (done),
      .err        (err)
   );

   // R1
   imm_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && (mode == MW'(AM_IMM))) |=> (!mem_req && done && !err));

   // R11
   illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && (mode > MW'(AM_POST))) |=> (err && !mem_req));

   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !mem_rdy) |=> busy);

endmodule

// File: tb/ea_resolve_unit_tb_top.sv
`timescale 1ns/1ps
module ea_resolve_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  mode = '0;
   logic [7:0]  afield = '0;
   logic [2:0]  rsel = '0;
   logic [15:0] pc = '0;
   logic [2:0]  rf_sel;
   logic [15:0] rf_data;
   logic        idx_ld = 1'b0;
   logic [15:0] idx_val = '0;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic        mem_rdy = 1'b0;
   logic [15:0] mem_rdata = '0;
   logic        busy, done, err;
   logic [15:0] ea, operand;

   always #2.5 clk = ~clk;

   ea_resolve_unit dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .afield(afield),
      .rsel(rsel), .pc(pc), .rf_sel(rf_sel), .rf_data(rf_data),
      .idx_ld(idx_ld), .idx_val(idx_val), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rdy(mem_rdy), .mem_rdata(mem_rdata), .busy(busy), .done(done),
      .err(err), .ea(ea), .operand(operand)
   );

   function automatic logic [15:0] f_mem(input logic [15:0] a);
      return {a[7:0], a[15:8]} ^ 16'h5A3C;
   endfunction

   function automatic logic [15:0] f_reg(input logic [2:0] s);
      return 16'h1000 + 16'(s) * 16'h0111;
   endfunction

   assign rf_data = f_reg(rf_sel);

   typedef struct {
      logic [15:0] ea;
      logic [15:0] op;
      logic        err;
      int          reads;
      string       tag;
   } exp_t;

   exp_t        q[$];
   int          checks = 0;
   int          errors = 0;
   int          lat = 0;
   int          wcnt = 0;
   int          rd_cnt = 0;
   bit          hs_pend = 0;
   bit          finished = 0;
   logic [15:0] xm = '0;

   task automatic chk(input bit ok, input string msg, input logic [15:0] act, input logic [15:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", msg, act, expv);
      end
   endtask

   // monitor and memory responder
   always @(negedge clk) begin
      if (done) begin
         if (q.size() == 0) begin
            chk(1'b0, "R10 unexpected done", 16'(done), 16'h0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(ea == e.ea, {e.tag, " ea"}, ea, e.ea);
            chk(operand == e.op, {e.tag, " operand"}, operand, e.op);
            chk(err == e.err, {e.tag, " err"}, 16'(err), 16'(e.err));
            chk(rd_cnt == e.reads, {e.tag, " read count"}, 16'(rd_cnt), 16'(e.reads));
         end
         rd_cnt = 0;
      end
      if (hs_pend) begin
         wcnt = 0;
         hs_pend = 0;
      end
      if (mem_req) begin
         if (wcnt >= lat) begin
            mem_rdy   = 1'b1;
            mem_rdata = f_mem(mem_addr);
            hs_pend   = 1;
            rd_cnt++;
         end else begin
            mem_rdy = 1'b0;
            wcnt++;
         end
      end else begin
         mem_rdy = 1'b0;
         wcnt = 0;
      end
   end

   task automatic issue(input logic [3:0] m, input logic [7:0] a, input logic [2:0] rs,
                        input logic [15:0] p, input bit ld, input logic [15:0] ldv,
                        input bit poke, input string tag);
      exp_t e;
      logic [15:0] z, r, s;
      z = {8'h00, a};
      s = {{8{a[7]}}, a};
      r = f_reg(rs);
      e.tag = tag; e.err = 1'b0; e.ea = '0; e.op = '0; e.reads = 0;
      case (m)
         4'd0:  begin e.op = s; end
         4'd1:  begin e.ea = z; e.reads = 1; end
         4'd2:  begin e.ea = f_mem(z); e.reads = 2; end
         4'd3:  begin e.op = r; end
         4'd4:  begin e.ea = r; e.reads = 1; end
         4'd5:  begin e.ea = p + z; e.reads = 1; end
         4'd6:  begin e.ea = z + r; e.reads = 1; end
         4'd7:  begin e.ea = z + xm; e.reads = 1; end
         4'd8:  begin e.ea = z + xm; e.reads = 1; xm = xm + 16'd1; end
         4'd9:  begin e.ea = f_mem(z + r); e.reads = 2; end
         4'd10: begin e.ea = f_mem(z) + r; e.reads = 2; end
         default: begin e.err = 1'b1; end
      endcase
      if (e.reads != 0) e.op = f_mem(e.ea);
      if (ld) xm = ldv;
      q.push_back(e);
      @(negedge clk);
      start = 1'b1; mode = m; afield = a; rsel = rs; pc = p;
      idx_ld = ld; idx_val = ldv;
      @(negedge clk);
      start = 1'b0; idx_ld = 1'b0;
      if (poke) begin
         start = 1'b1; mode = 4'd0; afield = 8'h11;
         @(negedge clk);
         start = 1'b0;
      end
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic load_x(input logic [15:0] v);
      @(negedge clk);
      idx_ld = 1'b1; idx_val = v;
      @(negedge clk);
      idx_ld = 1'b0;
      xm = v;
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(done == 1'b0, "R10 reset done", 16'(done), 16'h0);
      chk(busy == 1'b0, "R10 reset busy", 16'(busy), 16'h0);
      chk(mem_req == 1'b0, "R9 reset mem_req", 16'(mem_req), 16'h0);
      chk(err == 1'b0, "R11 reset err", 16'(err), 16'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      lat = 0;
      issue(4'd0, 8'h7F, 3'd0, 16'h0, 0, 16'h0, 0, "R1 immediate positive");
      issue(4'd0, 8'h80, 3'd0, 16'h0, 0, 16'h0, 0, "R1 immediate negative");
      issue(4'd1, 8'h42, 3'd0, 16'h0, 0, 16'h0, 0, "R2 direct");
      lat = 2;
      issue(4'd1, 8'hC3, 3'd0, 16'h0, 0, 16'h0, 0, "R9 direct with waits");
      issue(4'd2, 8'h10, 3'd0, 16'h0, 0, 16'h0, 0, "R3 indirect with waits");
      lat = 0;
      issue(4'd2, 8'hFF, 3'd0, 16'h0, 0, 16'h0, 0, "R3 indirect");
      issue(4'd3, 8'h00, 3'd5, 16'h0, 0, 16'h0, 0, "R4 register");
      issue(4'd4, 8'h00, 3'd2, 16'h0, 0, 16'h0, 0, "R4 register indirect");
      issue(4'd5, 8'h20, 3'd0, 16'hFFF0, 0, 16'h0, 0, "R5 relative wrap");
      issue(4'd5, 8'h04, 3'd0, 16'h0203, 0, 16'h0, 0, "R5 relative");
      issue(4'd6, 8'h33, 3'd7, 16'h0, 0, 16'h0, 0, "R5 base displacement");
      load_x(16'h0100);
      issue(4'd7, 8'h05, 3'd0, 16'h0, 0, 16'h0, 0, "R6 indexed");
      issue(4'd8, 8'h05, 3'd0, 16'h0, 0, 16'h0, 0, "R6 autoinc first");
      issue(4'd8, 8'h05, 3'd0, 16'h0, 0, 16'h0, 0, "R6 autoinc second");
      issue(4'd7, 8'h05, 3'd0, 16'h0, 0, 16'h0, 0, "R6 after autoinc");
      issue(4'd8, 8'h01, 3'd0, 16'h0, 1, 16'h0800, 0, "R6 load beats increment");
      issue(4'd7, 8'h00, 3'd0, 16'h0, 0, 16'h0, 0, "R6 loaded value");
      lat = 1;
      issue(4'd9, 8'h08, 3'd1, 16'h0, 0, 16'h0, 0, "R7 pre-indexed");
      issue(4'd10, 8'h08, 3'd1, 16'h0, 0, 16'h0, 0, "R8 post-indexed");
      lat = 3;
      issue(4'd1, 8'h55, 3'd0, 16'h0, 0, 16'h0, 1, "R10 start ignored while busy");
      lat = 0;
      issue(4'd11, 8'h12, 3'd0, 16'h0, 0, 16'h0, 0, "R11 illegal 11");
      issue(4'd15, 8'h12, 3'd0, 16'h0, 0, 16'h0, 0, "R11 illegal 15");
      repeat (4) @(negedge clk);
      chk(q.size() == 0, "R10 all results returned", 16'(q.size()), 16'h0);
      finish_run();
   end

endmodule